// File: doc/BRIEF.md
# Configuration Capability Chain Walker

This block looks up one capability inside a device's configuration space. It finds it by following the chain of next pointers from the head of a list, and it never guesses where a feature sits. A host pulses `start` with a 16-bit capability ID and a list selector. The selector picks the standard list in the low 256 bytes or the extended list in the 4 KB space. The walker then reads header dwords one at a time through a simple request/response port toward the configuration store. When it stops, it pulses `done` and holds the result until the next start.

The result is one of four outcomes. A match returns the matching header's dword offset and the header dword itself. A not-found result is reported with all flags low. A pointer error is raised when a pointer leaves the selected region. A loop error is raised when the hop budget runs out, which protects against circular chains. The two header layouts differ. A standard header carries an 8-bit ID in bits 7:0 and the next byte pointer in bits 15:8. An extended header carries a 16-bit ID in bits 15:0, a 4-bit version in bits 19:16 and the next byte pointer in bits 31:20.

The state machine uses these states: IDLE, HEAD_REQ, HEAD_WAIT, HDR_REQ, HDR_WAIT, EVAL and DONE. The transitions are:
- IDLE to HEAD_REQ on a start in standard mode.
- IDLE to HDR_REQ on a start in extended mode.
- HEAD_REQ to HEAD_WAIT, and HDR_REQ to HDR_WAIT, when a request is accepted.
- HEAD_WAIT to HDR_REQ on a usable head pointer, or to DONE on a zero or bad one.
- HDR_WAIT to EVAL on a response.
- EVAL to HDR_REQ to follow the next pointer, or to DONE on match, end of chain, bad pointer, hop limit or an empty extended space.
- DONE to IDLE after one cycle.

Top module: `cap_walker`

## Requirements
- R1: In standard mode the first read is dword 13 (byte 34h), and the head pointer is bits 7:0 of that dword. The low two bits of every pointer are cleared before use, so all reads are dword aligned (req_addr is a dword index).
- R2: A standard header matches when bits 7:0 equal target_id and target_id[15:8] is zero. Its next byte pointer is bits 15:8.
- R3: In extended mode the first read is dword 64 (byte 100h) and every read stays at dword 64 or above. A header matches when bits 15:0 equal target_id, and its next byte pointer is bits 31:20.
- R4: On a match, found=1, match_dw holds the header's dword offset and match_hdr holds the full header dword.
- R5: A zero head pointer or a zero next pointer (after masking) ends the walk as not-found: found, err_loop and err_ptr are all 0.
- R6: In extended mode, an all-zero dword at byte 100h ends the walk as not-found, whatever the target.
- R7: A nonzero standard pointer below 40h, or a nonzero extended pointer below 100h, ends the walk with err_ptr=1 and found=0. Standard-mode reads stay below dword 64.
- R8: At most STD_HOP_LIMIT (standard) or EXT_HOP_LIMIT (extended) headers are read. If the last allowed header neither matches nor ends the chain, the walk ends with err_loop=1.
- R9: Only one read is outstanding. After a request is accepted, req_valid stays low until the response has been taken.
- R10: A start pulse while busy=1 is ignored. The running walk keeps its original target.
- R11: done is a one-cycle pulse. At most one of found, err_loop and err_ptr is ever set, and all outputs are low after reset.
- R12: A request that is not yet accepted keeps req_valid high and req_addr stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken only when idle) |
| target_id | input | 16 | Capability ID to find |
| ext_sel | input | 1 | 0 = standard list, 1 = extended list |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Match found |
| err_loop | output | 1 | Hop budget exhausted |
| err_ptr | output | 1 | Pointer outside the selected region |
| match_dw | output | 10 | Dword offset of the matching header |
| match_hdr | output | 32 | Matching header dword |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Store accepts the request |
| req_addr | output | 10 | Dword address of the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Walker accepts read data |
| rsp_data | input | 32 | Read data |

## Verification
Both lists are swept over every chain length up to the hop limit and every target position, including a target that is absent. Entries sit at descending, scattered offsets, and low pointer bits are set, which separates real pointer following and masking from fixed-location guesses. Response latency and request stalls vary from run to run, so a handshake slip shows up as a wrong result. Separate patterns cover these cases:
- circular chains and over-length chains, which tell the loop guard apart from normal chain ends;
- pointers into the header area, which exercise the region checks;
- an empty extended space;
- a target with upper bits set in standard mode;
- a second start during a walk.

// File: rtl/cap_walk_pkg.sv
package cap_walk_pkg;

    localparam int CFG_DW_W = 10;   // dword index across 4 KB
    localparam int CAP_ID_W = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HEAD_REQ,
        S_HEAD_WAIT,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_EVAL,
        S_DONE
    } walk_state_e;

    typedef struct packed {
        logic [CAP_ID_W-1:0] id;
        logic [CFG_DW_W-1:0] next_dw;
        logic                next_zero;
        logic                next_low;
    } hdr_fields_t;

endpackage

// File: rtl/cap_hdr_decode.sv
module cap_hdr_decode
    import cap_walk_pkg::*;
(
    input  logic [31:0] hdr,
    input  logic        is_ext,
    output hdr_fields_t fields
);

    // Version and the low pointer bits play no part in the walk.
    logic unused_hdr_bits;
    assign unused_hdr_bits = ^{hdr[21:16]};

    always_comb begin
        if (is_ext) begin
            fields.id        = hdr[15:0];
            fields.next_dw   = hdr[31:22];
            fields.next_zero = (hdr[31:22] == '0);
            fields.next_low  = (hdr[31:22] != '0) && (hdr[31:28] == '0);
        end else begin
            fields.id        = {8'h00, hdr[7:0]};
            fields.next_dw   = {4'h0, hdr[15:10]};
            fields.next_zero = (hdr[15:10] == '0);
            fields.next_low  = (hdr[15:10] != '0) && (hdr[15:14] == 2'b00);
        end
    end

endmodule

// File: rtl/cap_hop_count.sv
module cap_hop_count #(
    parameter int STD_HOP_LIMIT = 48,
    parameter int EXT_HOP_LIMIT = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic is_ext,
    output logic at_limit
);

    localparam int MAX_LIM = (EXT_HOP_LIMIT > STD_HOP_LIMIT) ? EXT_HOP_LIMIT : STD_HOP_LIMIT;
    localparam int CNT_W   = $clog2(MAX_LIM + 1);
    localparam logic [CNT_W-1:0] STD_LIM_C = CNT_W'(STD_HOP_LIMIT);
    localparam logic [CNT_W-1:0] EXT_LIM_C = CNT_W'(EXT_HOP_LIMIT);

    logic [CNT_W-1:0] hops_q;
    logic [CNT_W-1:0] lim;

    assign lim      = is_ext ? EXT_LIM_C : STD_LIM_C;
    assign at_limit = (hops_q >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hops_q <= '0;
        end else if (clr) begin
            hops_q <= '0;
        end else if (inc && !at_limit) begin
            hops_q <= hops_q + 1'b1;
        end
    end

    // R8: header reads never exceed the selected budget
    p_hop_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);

endmodule

// File: rtl/cap_walker.sv
module cap_walker
    import cap_walk_pkg::*;
#(
    parameter int STD_HOP_LIMIT = 48,
    parameter int EXT_HOP_LIMIT = 960
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CAP_ID_W-1:0] target_id,
    input  logic                ext_sel,
    output logic                busy,
    output logic                done,
    output logic                found,
    output logic                err_loop,
    output logic                err_ptr,
    output logic [CFG_DW_W-1:0] match_dw,
    output logic [31:0]         match_hdr,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [CFG_DW_W-1:0] req_addr,
    input  logic                rsp_valid,
    output logic                rsp_ready,
    input  logic [31:0]         rsp_data
);

    localparam logic [CFG_DW_W-1:0] HEAD_DW     = CFG_DW_W'(13);  // byte 34h
    localparam logic [CFG_DW_W-1:0] EXT_BASE_DW = CFG_DW_W'(64);  // byte 100h

    walk_state_e state, nxt;

    logic [CAP_ID_W-1:0] tgt_q;
    logic                ext_q;
    logic                first_q;
    logic [CFG_DW_W-1:0] cur_dw;
    logic [31:0]         hdr_q;

    hdr_fields_t dec;
    logic [31:0] dec_in;
    logic        dec_ext;
    logic        at_limit;
    logic        take;
    logic        head_rsp;
    logic        hdr_rsp;
    logic        is_match;
    logic        ext_empty;
    logic        eval_stop;

    assign take     = (state == S_IDLE) && start;
    assign head_rsp = (state == S_HEAD_WAIT) && rsp_valid;
    assign hdr_rsp  = (state == S_HDR_WAIT) && rsp_valid;

    // The head byte is fed through the standard decoder as if it were a next field.
    assign dec_in  = (state == S_HEAD_WAIT) ? {16'h0000, rsp_data[7:0], 8'h00} : hdr_q;
    assign dec_ext = (state == S_HEAD_WAIT) ? 1'b0 : ext_q;

    cap_hdr_decode dec_i (
        .hdr    (dec_in),
        .is_ext (dec_ext),
        .fields (dec)
    );

    cap_hop_count #(
        .STD_HOP_LIMIT (STD_HOP_LIMIT),
        .EXT_HOP_LIMIT (EXT_HOP_LIMIT)
    ) hop_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (take),
        .inc      (hdr_rsp),
        .is_ext   (ext_q),
        .at_limit (at_limit)
    );

    assign is_match  = (dec.id == tgt_q);
    assign ext_empty = ext_q && first_q && (hdr_q == 32'h0);
    assign eval_stop = ext_empty || is_match || dec.next_zero || dec.next_low || at_limit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start)     nxt = ext_sel ? S_HDR_REQ : S_HEAD_REQ;
            S_HEAD_REQ:  if (req_ready) nxt = S_HEAD_WAIT;
            S_HEAD_WAIT: if (rsp_valid) nxt = (dec.next_zero || dec.next_low) ? S_DONE : S_HDR_REQ;
            S_HDR_REQ:   if (req_ready) nxt = S_HDR_WAIT;
            S_HDR_WAIT:  if (rsp_valid) nxt = S_EVAL;
            S_EVAL:      nxt = eval_stop ? S_DONE : S_HDR_REQ;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_valid = (state == S_HEAD_REQ) || (state == S_HDR_REQ);
        rsp_ready = (state == S_HEAD_WAIT) || (state == S_HDR_WAIT);
        done      = (state == S_DONE);
        busy      = (state != S_IDLE);
        req_addr  = cur_dw;
    end

    // Walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q   <= '0;
            ext_q   <= 1'b0;
            first_q <= 1'b0;
            cur_dw  <= '0;
            hdr_q   <= '0;
        end else begin
            if (take) begin
                tgt_q   <= target_id;
                ext_q   <= ext_sel;
                first_q <= 1'b1;
                cur_dw  <= ext_sel ? EXT_BASE_DW : HEAD_DW;
            end
            if (head_rsp) cur_dw <= dec.next_dw;
            if (hdr_rsp)  hdr_q  <= rsp_data;
            if (state == S_EVAL) begin
                first_q <= 1'b0;
                if (!eval_stop) cur_dw <= dec.next_dw;
            end
        end
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n || take) begin
            found     <= 1'b0;
            err_loop  <= 1'b0;
            err_ptr   <= 1'b0;
            match_dw  <= '0;
            match_hdr <= '0;
        end else if (head_rsp) begin
            if (dec.next_low) err_ptr <= 1'b1;
        end else if (state == S_EVAL && !ext_empty) begin
            if (is_match) begin
                found     <= 1'b1;
                match_dw  <= cur_dw;
                match_hdr <= hdr_q;
            end else if (dec.next_zero) begin
                found <= 1'b0;
            end else if (dec.next_low) begin
                err_ptr <= 1'b1;
            end else if (at_limit) begin
                err_loop <= 1'b1;
            end
        end
    end

    // R9: no second request while a response is owed
    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R12: pending request holds valid and address
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: outcome flags are exclusive
    p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({found, err_loop, err_ptr}));

    // R3: extended reads stay in the extended region
    p_ext_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ext_q) |-> (req_addr >= EXT_BASE_DW));

    // R7: standard reads stay in the low 256 bytes
    p_std_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !ext_q) |-> (req_addr < EXT_BASE_DW));

endmodule

// File: tb/cap_walker_tb_top.sv
`timescale 1ns/1ps
module cap_walker_tb_top;

    localparam int SL = 6;
    localparam int EL = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] target_id = '0;
    logic        ext_sel = 1'b0;
    logic        busy, done, found, err_loop, err_ptr;
    logic [9:0]  match_dw;
    logic [31:0] match_hdr;
    logic        req_valid, req_ready, rsp_ready;
    logic [9:0]  req_addr;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    always #2 clk = ~clk;

    cap_walker #(.STD_HOP_LIMIT(SL), .EXT_HOP_LIMIT(EL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .target_id(target_id), .ext_sel(ext_sel),
        .busy(busy), .done(done), .found(found), .err_loop(err_loop), .err_ptr(err_ptr),
        .match_dw(match_dw), .match_hdr(match_hdr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    // Configuration store model
    logic [31:0] cfg_mem [1024];
    logic        pend;
    logic        stall = 1'b0;
    int          lat = 0;
    int          cd;
    logic [9:0]  paddr;
    logic [9:0]  first_addr;
    int          rd_count;
    int          viol;
    logic [31:0] cyc = '0;

    assign req_ready = !pend && !rsp_valid && !(stall && cyc[0]);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            pend <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0; cd <= 0;
            paddr <= '0; first_addr <= '0; rd_count <= 0; viol <= 0;
        end else begin
            if (start && !busy) rd_count <= 0;
            if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
            if (pend) begin
                if (cd == 0) begin
                    rsp_valid <= 1'b1; rsp_data <= cfg_mem[paddr]; pend <= 1'b0;
                end else cd <= cd - 1;
            end
            if (req_valid && (pend || rsp_valid)) viol <= viol + 1;
            if (req_valid && req_ready) begin
                pend <= 1'b1; paddr <= req_addr; cd <= lat;
                if (rd_count == 0) first_addr <= req_addr;
                rd_count <= rd_count + 1;
            end
        end
    end

    int nchk = 0;
    int nerr = 0;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic clr_mem();
        for (int i = 0; i < 1024; i++) cfg_mem[i] = 32'h0;
    endtask

    function automatic logic [7:0] soff(input int i);
        return 8'(8'hF0 - 8'h10 * i);
    endfunction
    function automatic logic [7:0] sid(input int i);
        return 8'(16 + i);
    endfunction
    function automatic logic [31:0] std_hdr(input int i, input int n);
        logic [7:0] nx;
        nx = (i == n - 1) ? 8'h00 : (soff(i + 1) | 8'h01);
        return {16'(16'hA500 + i), nx, sid(i)};
    endfunction
    function automatic logic [11:0] eoff(input int i);
        return (i == 0) ? 12'h100 : 12'(12'hE00 - 12'h080 * i);
    endfunction
    function automatic logic [15:0] eid(input int i);
        return 16'(16'h0100 + 3 * i);
    endfunction
    function automatic logic [31:0] ext_hdr(input int i, input int n);
        logic [11:0] nx;
        nx = (i == n - 1) ? 12'h000 : (eoff(i + 1) | 12'h002);
        return {nx, 4'(i), eid(i)};
    endfunction

    task automatic build_std(input int n);
        cfg_mem[13] = (n > 0) ? {24'h0, soff(0) | 8'h02} : 32'h0;
        for (int i = 0; i < n; i++) cfg_mem[soff(i) >> 2] = std_hdr(i, n);
    endtask
    task automatic build_ext(input int n);
        for (int i = 0; i < n; i++) cfg_mem[eoff(i) >> 2] = ext_hdr(i, n);
    endtask

    task automatic wait_done(input string tag);
        int t;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL %s R11: actual=no done expected=done", tag);
        end
    endtask

    task automatic walk(input logic [15:0] tgt, input logic ext, input string tag);
        @(negedge clk);
        start = 1'b1; target_id = tgt; ext_sel = ext;
        @(negedge clk);
        start = 1'b0;
        wait_done(tag);
    endtask

    task automatic expect_res(input string tag, input bit ef, input bit el, input bit ep,
                              input logic [9:0] edw, input logic [31:0] eh);
        chk({tag, " found"}, 32'(found), 32'(ef));
        chk({tag, " err_loop"}, 32'(err_loop), 32'(el));
        chk({tag, " err_ptr"}, 32'(err_ptr), 32'(ep));
        if (ef) begin
            chk({tag, " match_dw"}, 32'(match_dw), 32'(edw));
            chk({tag, " match_hdr"}, match_hdr, eh);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        string tg;
        clr_mem();
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset busy", 32'(busy), 0);
        chk("R11 reset done", 32'(done), 0);
        chk("R11 reset flags", 32'({found, err_loop, err_ptr}), 0);
        chk("R11 reset req_valid", 32'(req_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R4 R5 R8: standard sweep, chain lengths up to the hop limit
        for (int n = 1; n <= SL; n++) begin
            for (int k = 0; k <= n; k++) begin
                clr_mem(); build_std(n);
                lat = (n + k) % 3; stall = k[0];
                tg = $sformatf("R4 std n=%0d k=%0d", n, k);
                walk({8'h00, (k < n) ? sid(k) : 8'hEE}, 1'b0, tg);
                if (k < n) expect_res(tg, 1, 0, 0, 10'(soff(k) >> 2), std_hdr(k, n));
                else       expect_res({tg, " R5"}, 0, 0, 0, '0, '0);
                if (k == 0) chk($sformatf("R1 std first read n=%0d", n), 32'(first_addr), 13);
                @(negedge clk);
                chk("R11 done pulse", 32'(done), 0);
            end
        end

        // R3 R4 R5 R8: extended sweep
        for (int n = 1; n <= EL; n++) begin
            for (int k = 0; k <= n; k++) begin
                clr_mem(); build_ext(n);
                lat = (n * 2 + k) % 3; stall = ~k[0];
                tg = $sformatf("R3 ext n=%0d k=%0d", n, k);
                walk((k < n) ? eid(k) : 16'h0EEE, 1'b1, tg);
                if (k < n) expect_res(tg, 1, 0, 0, 10'(eoff(k) >> 2), ext_hdr(k, n));
                else       expect_res({tg, " R5"}, 0, 0, 0, '0, '0);
                if (k == 0) chk($sformatf("R3 ext first read n=%0d", n), 32'(first_addr), 64);
            end
        end
        lat = 1; stall = 1'b0;

        // R5: zero head pointer
        clr_mem();
        walk(16'h0010, 1'b0, "R5 head zero");
        expect_res("R5 head zero", 0, 0, 0, '0, '0);

        // R7: head pointer into header area
        clr_mem(); cfg_mem[13] = 32'h0000_0020;
        walk(16'h0010, 1'b0, "R7 head low");
        expect_res("R7 head low", 0, 0, 1, '0, '0);

        // R7: mid-chain pointer below 40h
        clr_mem(); build_std(2);
        cfg_mem[soff(0) >> 2] = {16'hA500, 8'h3C, sid(0)};
        walk(16'h00EE, 1'b0, "R7 std next low");
        expect_res("R7 std next low", 0, 0, 1, '0, '0);

        // R6: empty extended space, with a nonzero and a zero target
        clr_mem();
        walk(16'h0001, 1'b1, "R6 ext empty");
        expect_res("R6 ext empty", 0, 0, 0, '0, '0);
        walk(16'h0000, 1'b1, "R6 ext empty target0");
        expect_res("R6 ext empty target0", 0, 0, 0, '0, '0);

        // R7: extended pointer below 100h
        clr_mem(); cfg_mem[64] = {12'h0C0, 4'h1, 16'h0001};
        walk(16'h0002, 1'b1, "R7 ext next low");
        expect_res("R7 ext next low", 0, 0, 1, '0, '0);

        // R8: circular standard chain
        clr_mem(); cfg_mem[13] = 32'h80;
        cfg_mem[8'h80 >> 2] = {16'h0, 8'h90, 8'h01};
        cfg_mem[8'h90 >> 2] = {16'h0, 8'h80, 8'h02};
        walk(16'h0003, 1'b0, "R8 std loop");
        expect_res("R8 std loop", 0, 1, 0, '0, '0);
        chk("R8 std loop reads", 32'(rd_count), 32'(SL + 1));

        // R8: chain one longer than the budget
        clr_mem(); build_std(SL + 1);
        walk(16'h00EE, 1'b0, "R8 std overlong absent");
        expect_res("R8 std overlong absent", 0, 1, 0, '0, '0);
        walk({8'h00, sid(SL)}, 1'b0, "R8 std beyond limit");
        expect_res("R8 std beyond limit", 0, 1, 0, '0, '0);
        walk({8'h00, sid(SL - 1)}, 1'b0, "R8 std at limit");
        expect_res("R8 std at limit", 1, 0, 0, 10'(soff(SL - 1) >> 2), std_hdr(SL - 1, SL + 1));

        // R8: extended self-loop
        clr_mem(); cfg_mem[64] = {12'h100, 4'h0, 16'h0007};
        walk(16'h0008, 1'b1, "R8 ext loop");
        expect_res("R8 ext loop", 0, 1, 0, '0, '0);

        // R2: upper target bits in standard mode never match
        clr_mem(); build_std(3);
        walk(16'h0100 | {8'h00, sid(1)}, 1'b0, "R2 std upper bits");
        expect_res("R2 std upper bits", 0, 0, 0, '0, '0);

        // R10: second start during a walk is ignored
        clr_mem(); build_std(4); lat = 2;
        @(negedge clk);
        start = 1'b1; target_id = {8'h00, sid(3)}; ext_sel = 1'b0;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 busy mid-walk", 32'(busy), 1);
        start = 1'b1; target_id = {8'h00, sid(0)};
        @(negedge clk); start = 1'b0;
        wait_done("R10");
        expect_res("R10 restart ignored", 1, 0, 0, 10'(soff(3) >> 2), std_hdr(3, 4));

        // R9 R12: store model saw no overlapping request
        chk("R9 overlapping requests", 32'(viol), 0);

        summary();
        $finish;
    end

endmodule